// File: doc/BRIEF.md
# Ternary Reversible Gate Cascade Evaluator

This block runs a programmed cascade of three-valued reversible gates over a small set of trit lines. Each line carries one trit in a two-bit code. The circuit is a list of genes, with one gate per column. Each gene names a control line, a target line and a gate kind.

Software-side logic fills the gene list and a column-count register through a simple write port. It then offers an input vector on a valid/ready pair. The block applies the columns one per clock, in ascending column order. It then presents the transformed vector, together with two error flags, on an output valid/ready pair.

A gate whose control line equals its target line is an unconditional single-trit permutation. Any other gate is a controlled gate: it permutes its target only while the control trit holds the value 2, and it never alters the control line.

The sequencing is a three-state machine. **ST_IDLE** accepts writes and input vectors. **ST_RUN** applies one column per clock. **ST_DONE** holds the result until it is taken. It has these transitions:
- *accept_run* (ST_IDLE to ST_RUN, on an input handshake with a nonzero count).
- *accept_empty* (ST_IDLE to ST_DONE, on an input handshake with a zero count).
- *last_column* (ST_RUN to ST_DONE, after the final active column is applied).
- *result_taken* (ST_DONE to ST_IDLE, on the output handshake).

Top module: `ter_cascade_eval`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. Every gene slot resets to control 0, target 0, kind 0, and the column count resets to 0.
- R2: Gene and count writes take effect only in ST_IDLE. A write presented while a vector is being evaluated or held has no effect on this or any later evaluation.
- R3: `cnt_val` sets the number of active columns. A value above MAX_COLS is stored as MAX_COLS. A count of 0 makes the output equal to the input.
- R4: The gate kind codes are: 0 leaves the trit unchanged, 1 gives x+1, 2 gives x+2, 3 gives 2x+1, 4 gives 2x+2, and 5 gives 2x. All arithmetic is mod 3.
- R5: A gene whose control line equals its target line transforms the target unconditionally.
- R6: A gene with distinct control and target lines transforms the target only when the control trit is 2. Otherwise the target passes unchanged. The control line is never changed.
- R7: Columns 0 to N-1 are applied strictly in order, one per clock. `out_valid` rises exactly N clock edges after the edge that accepted the input.
- R8: Once raised, `out_valid`, `out_vec` and both error flags hold steady until `out_ready` is seen. On the edge that takes the result, the block returns to ST_IDLE with `in_ready` high.
- R9: The trit codes are 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2. Code 2'b11 is illegal. An input holding it sets `err_trit` for that result. An illegal line is never transformed, never fires as a control, and is never produced from a legal one.
- R10: A gene with kind 6 or 7, or with a control or target index of NUM_LINES or above, acts as identity and sets `err_gate` for that result.
- R11: Line i occupies bits [2i+1:2i] of `in_vec` and `out_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gene_we | input | 1 | Gene write strobe |
| gene_addr | input | ADDR_W (5) | Column written |
| gene_ctrl | input | 3 | Control line index |
| gene_tgt | input | 3 | Target line index |
| gene_kind | input | 3 | Gate kind code |
| cnt_we | input | 1 | Column-count write strobe |
| cnt_val | input | LEN_W (6) | Number of active columns |
| in_valid | input | 1 | Input vector offered |
| in_ready | output | 1 | Block can accept a vector |
| in_vec | input | 2*NUM_LINES (10) | Input trit vector |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken |
| out_vec | output | 2*NUM_LINES (10) | Result trit vector |
| err_trit | output | 1 | Input held an illegal trit code |
| err_gate | output | 1 | A malformed gene was applied |

## Verification
With a count of N, the result is due on the N-th clock edge after the accepting edge. The bench counts the falling edges it waits before `out_valid` appears and compares that number with N.

A behavioural model is updated on the rising edge from the same stimulus. It predicts `in_ready` and `out_valid` on every cycle, and it predicts the vector and both flags whenever a result is held. All of these are compared half a cycle after each edge, so no result depends on process order.

Writes placed inside an evaluation are judged on the following run, which must still use the old genes and the old count.

// File: rtl/ter_pkg.sv
package ter_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t TRIT_0   = 2'b00;
    localparam trit_t TRIT_1   = 2'b01;
    localparam trit_t TRIT_2   = 2'b10;
    localparam trit_t TRIT_BAD = 2'b11;

    localparam int FIELD_W = 3;

    localparam logic [FIELD_W-1:0] KIND_PASS     = 3'd0;
    localparam logic [FIELD_W-1:0] KIND_ADD1     = 3'd1;
    localparam logic [FIELD_W-1:0] KIND_ADD2     = 3'd2;
    localparam logic [FIELD_W-1:0] KIND_DBL_ADD1 = 3'd3;
    localparam logic [FIELD_W-1:0] KIND_DBL_ADD2 = 3'd4;
    localparam logic [FIELD_W-1:0] KIND_DBL      = 3'd5;

    typedef struct packed {
        logic [FIELD_W-1:0] ctrl;
        logic [FIELD_W-1:0] tgt;
        logic [FIELD_W-1:0] kind;
    } gene_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } eval_state_t;

    // Single-trit permutation; illegal codes and unknown kinds pass through.
    function automatic trit_t trit_xform(input trit_t x, input logic [FIELD_W-1:0] kind);
        trit_t y;
        y = x;
        if (x != TRIT_BAD) begin
            unique case (kind)
                KIND_ADD1:     y = (x == TRIT_0) ? TRIT_1 : (x == TRIT_1) ? TRIT_2 : TRIT_0;
                KIND_ADD2:     y = (x == TRIT_0) ? TRIT_2 : (x == TRIT_1) ? TRIT_0 : TRIT_1;
                KIND_DBL_ADD1: y = (x == TRIT_0) ? TRIT_1 : (x == TRIT_1) ? TRIT_0 : TRIT_2;
                KIND_DBL_ADD2: y = (x == TRIT_0) ? TRIT_2 : (x == TRIT_1) ? TRIT_1 : TRIT_0;
                KIND_DBL:      y = (x == TRIT_0) ? TRIT_0 : (x == TRIT_1) ? TRIT_2 : TRIT_1;
                default:       y = x;
            endcase
        end
        return y;
    endfunction

endpackage

// File: rtl/ter_gene_store.sv
module ter_gene_store
    import ter_pkg::*;
#(
    parameter int MAX_COLS = 32,
    parameter int ADDR_W   = $clog2(MAX_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  gene_t             wr_gene,
    input  logic [ADDR_W-1:0] rd_addr,
    output gene_t             rd_gene
);

    gene_t slot_q [MAX_COLS];

    for (genvar c = 0; c < MAX_COLS; c++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[c] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(c))) begin
                slot_q[c] <= wr_gene;
            end
        end
    end

    always_comb begin
        rd_gene = '0;
        for (int c = 0; c < MAX_COLS; c++) begin
            if (rd_addr == ADDR_W'(c)) begin
                rd_gene = slot_q[c];
            end
        end
    end

endmodule

// File: rtl/ter_column_apply.sv
module ter_column_apply
    import ter_pkg::*;
#(
    parameter int NUM_LINES = 5,
    parameter int VEC_W     = 2 * NUM_LINES
) (
    input  logic [VEC_W-1:0] vec_in,
    input  gene_t            gene,
    output logic [VEC_W-1:0] vec_out,
    output logic             malformed
);

    logic [NUM_LINES-1:0] ctrl_hit;
    logic                 ctrl_ok;
    logic                 tgt_ok;
    logic                 kind_ok;
    logic                 legal;
    logic                 fire;

    assign ctrl_ok = (32'(gene.ctrl) < NUM_LINES);
    assign tgt_ok  = (32'(gene.tgt) < NUM_LINES);
    assign kind_ok = (gene.kind <= KIND_DBL);
    assign legal   = ctrl_ok && tgt_ok && kind_ok;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ctrl
        assign ctrl_hit[i] = (gene.ctrl == FIELD_W'(i)) && (vec_in[2*i +: 2] == TRIT_2);
    end

    assign fire      = legal && ((gene.ctrl == gene.tgt) || (|ctrl_hit));
    assign malformed = !legal;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign vec_out[2*i +: 2] = (fire && (gene.tgt == FIELD_W'(i)))
                                 ? trit_xform(vec_in[2*i +: 2], gene.kind)
                                 : vec_in[2*i +: 2];
    end

endmodule

// File: rtl/ter_cascade_eval.sv
module ter_cascade_eval
    import ter_pkg::*;
#(
    parameter int NUM_LINES = 5,
    parameter int MAX_COLS  = 32,
    parameter int ADDR_W    = $clog2(MAX_COLS),
    parameter int LEN_W     = $clog2(MAX_COLS + 1),
    parameter int VEC_W     = 2 * NUM_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gene_we,
    input  logic [ADDR_W-1:0] gene_addr,
    input  logic [2:0]        gene_ctrl,
    input  logic [2:0]        gene_tgt,
    input  logic [2:0]        gene_kind,
    input  logic              cnt_we,
    input  logic [LEN_W-1:0]  cnt_val,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VEC_W-1:0]  in_vec,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VEC_W-1:0]  out_vec,
    output logic              err_trit,
    output logic              err_gate
);

    localparam logic [LEN_W-1:0] CNT_CAP = LEN_W'(MAX_COLS);

    eval_state_t          state_q;
    eval_state_t          state_d;
    logic [ADDR_W-1:0]    col_q;
    logic [LEN_W-1:0]     len_q;
    logic [VEC_W-1:0]     vec_q;
    logic                 err_trit_q;
    logic                 err_gate_q;
    logic                 accept;
    logic                 last_col;
    logic                 is_idle;
    gene_t                wr_gene;
    gene_t                cur_gene;
    logic [VEC_W-1:0]     col_out;
    logic                 col_bad;
    logic [NUM_LINES-1:0] bad_in;

    assign is_idle  = (state_q == ST_IDLE);
    assign accept   = is_idle && in_valid;
    assign last_col = ({1'b0, col_q} == (len_q - LEN_W'(1)));
    assign wr_gene  = '{ctrl: gene_ctrl, tgt: gene_tgt, kind: gene_kind};

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk_in
        assign bad_in[i] = (in_vec[2*i +: 2] == TRIT_BAD);
    end

    ter_gene_store #(
        .MAX_COLS (MAX_COLS),
        .ADDR_W   (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gene_we && is_idle),
        .wr_addr (gene_addr),
        .wr_gene (wr_gene),
        .rd_addr (col_q),
        .rd_gene (cur_gene)
    );

    ter_column_apply #(
        .NUM_LINES (NUM_LINES),
        .VEC_W     (VEC_W)
    ) u_col (
        .vec_in    (vec_q),
        .gene      (cur_gene),
        .vec_out   (col_out),
        .malformed (col_bad)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept_run, accept_empty, last_column, result_taken
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = (len_q == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (last_col) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (out_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_RUN:  in_ready  = 1'b0;
            ST_DONE: out_valid = 1'b1;
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    assign out_vec  = vec_q;
    assign err_trit = err_trit_q;
    assign err_gate = err_gate_q;

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q      <= '0;
            col_q      <= '0;
            vec_q      <= '0;
            err_trit_q <= 1'b0;
            err_gate_q <= 1'b0;
        end else begin
            if (is_idle && cnt_we) begin
                len_q <= (cnt_val > CNT_CAP) ? CNT_CAP : cnt_val;
            end
            if (accept) begin
                vec_q      <= in_vec;
                col_q      <= '0;
                err_trit_q <= |bad_in;
                err_gate_q <= 1'b0;
            end else if (state_q == ST_RUN) begin
                vec_q      <= col_out;
                err_gate_q <= err_gate_q | col_bad;
                col_q      <= col_q + ADDR_W'(1);
            end
        end
    end

endmodule

// File: rtl/ter_cascade_chk.sv
module ter_cascade_chk #(
    parameter int NUM_LINES = 5,
    parameter int LEN_W     = 6,
    parameter int VEC_W     = 2 * NUM_LINES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_vec,
    input logic             err_trit,
    input logic             err_gate,
    input logic [LEN_W-1:0] len_q
);

    logic [LEN_W:0]   run_cnt;
    logic [LEN_W-1:0] len_snap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            len_snap <= '0;
        end else if (in_valid && in_ready) begin
            run_cnt  <= '0;
            len_snap <= len_q;
        end else if (!out_valid && !in_ready) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    function automatic logic has_bad(input logic [VEC_W-1:0] v);
        logic b;
        b = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (v[2*i +: 2] == 2'b11) b = 1'b1;
        end
        return b;
    endfunction

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)
                                       && $stable(err_trit) && $stable(err_gate)));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (run_cnt == {1'b0, len_snap}));

    p_no_new_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !err_trit) |-> !has_bad(out_vec));

endmodule

bind ter_cascade_eval ter_cascade_chk #(
    .NUM_LINES (NUM_LINES),
    .LEN_W     (LEN_W),
    .VEC_W     (VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vec   (out_vec),
    .err_trit  (err_trit),
    .err_gate  (err_gate),
    .len_q     (len_q)
);

// File: tb/sim_ter_cascade_eval.sv
module sim_ter_cascade_eval;

    localparam int NL = 5;
    localparam int MC = 32;
    localparam int VW = 2 * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gene_we = 1'b0;
    logic [4:0]    gene_addr = '0;
    logic [2:0]    gene_ctrl = '0;
    logic [2:0]    gene_tgt = '0;
    logic [2:0]    gene_kind = '0;
    logic          cnt_we = 1'b0;
    logic [5:0]    cnt_val = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [VW-1:0] in_vec = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [VW-1:0] out_vec;
    logic          err_trit;
    logic          err_gate;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ter_cascade_eval u0 (
        .clk(clk), .rst_n(rst_n),
        .gene_we(gene_we), .gene_addr(gene_addr), .gene_ctrl(gene_ctrl),
        .gene_tgt(gene_tgt), .gene_kind(gene_kind),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .in_valid(in_valid), .in_ready(in_ready), .in_vec(in_vec),
        .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
        .err_trit(err_trit), .err_gate(err_gate)
    );

    // ---------------- behavioural reference model ----------------
    int m_ctrl [MC];
    int m_tgt  [MC];
    int m_kind [MC];
    int m_len;
    int m_state;   // 0 idle, 1 running, 2 holding
    int m_left;
    logic [VW-1:0] m_vec;
    bit m_et, m_eg;

    task automatic model_eval(input logic [VW-1:0] v, output logic [VW-1:0] o,
                              output bit et, output bit eg);
        int ln [NL];
        et = 0; eg = 0;
        for (int i = 0; i < NL; i++) begin
            ln[i] = int'(v[2*i +: 2]);
            if (ln[i] == 3) et = 1;
        end
        for (int c = 0; c < m_len; c++) begin
            if (m_kind[c] > 5 || m_ctrl[c] >= NL || m_tgt[c] >= NL) begin
                eg = 1;
            end else if (ln[m_tgt[c]] != 3 &&
                         (m_ctrl[c] == m_tgt[c] || ln[m_ctrl[c]] == 2)) begin
                int x;
                x = ln[m_tgt[c]];
                case (m_kind[c])
                    1: x = (x + 1) % 3;
                    2: x = (x + 2) % 3;
                    3: x = (2 * x + 1) % 3;
                    4: x = (2 * x + 2) % 3;
                    5: x = (2 * x) % 3;
                    default: x = x;
                endcase
                ln[m_tgt[c]] = x;
            end
        end
        for (int i = 0; i < NL; i++) o[2*i +: 2] = 2'(ln[i]);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < MC; c++) begin
                m_ctrl[c] = 0; m_tgt[c] = 0; m_kind[c] = 0;
            end
            m_len = 0; m_state = 0; m_left = 0;
            m_vec = '0; m_et = 0; m_eg = 0;
        end else begin
            case (m_state)
                0: begin
                    if (in_valid) begin
                        model_eval(in_vec, m_vec, m_et, m_eg);
                        m_left  = m_len;
                        m_state = (m_len == 0) ? 2 : 1;
                    end
                    if (cnt_we) m_len = (int'(cnt_val) > MC) ? MC : int'(cnt_val);
                    if (gene_we) begin
                        m_ctrl[gene_addr] = int'(gene_ctrl);
                        m_tgt[gene_addr]  = int'(gene_tgt);
                        m_kind[gene_addr] = int'(gene_kind);
                    end
                end
                1: begin
                    m_left = m_left - 1;
                    if (m_left == 0) m_state = 2;
                end
                default: if (out_ready) m_state = 0;
            endcase
        end
    end

    // Compare every cycle, half a period after the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (in_ready !== (m_state == 0) || out_valid !== (m_state == 2)) begin
                errors++;
                $display("FAIL R7/R8 handshake: in_ready=%0b out_valid=%0b expected %0b %0b",
                         in_ready, out_valid, m_state == 0, m_state == 2);
            end
            if (m_state == 2) begin
                checks++;
                if (out_vec !== m_vec || err_trit !== m_et || err_gate !== m_eg) begin
                    errors++;
                    $display("FAIL R4/R5/R6/R9/R10 result: vec=%h et=%0b eg=%0b expected %h %0b %0b",
                             out_vec, err_trit, err_gate, m_vec, m_et, m_eg);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wgene(input int a, input int c, input int t, input int k);
        @(negedge clk);
        gene_we = 1; gene_addr = 5'(a); gene_ctrl = 3'(c); gene_tgt = 3'(t); gene_kind = 3'(k);
        @(negedge clk);
        gene_we = 0;
    endtask

    task automatic wcnt(input int n);
        @(negedge clk);
        cnt_we = 1; cnt_val = 6'(n);
        @(negedge clk);
        cnt_we = 0;
    endtask

    logic [VW-1:0] r_vec;
    bit r_et, r_eg;

    task automatic run(input logic [VW-1:0] v, input int exp_lat, input int hold, input string req);
        int lat;
        @(negedge clk);
        in_valid = 1; in_vec = v;
        @(negedge clk);
        in_valid = 0;
        lat = 0;
        while (!out_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, req, lat, exp_lat);
        r_vec = out_vec; r_et = err_trit; r_eg = err_gate;
        repeat (hold) @(negedge clk);
        out_ready = 1;
        @(negedge clk);
        out_ready = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset", {in_ready, out_valid}, 2'b10);
        // R1/R3: empty count after reset passes input through
        run(10'h249, 0, 0, "R3 zero count latency");
        check(r_vec == 10'h249, "R1 R3 passthrough", r_vec, 10'h249);

        // R5: uncontrolled gate, line1 2 -> x+1 = 0
        wgene(0, 1, 1, 1);
        wcnt(1);
        run(10'h008, 1, 0, "R7 latency one");
        check(r_vec == 10'h000, "R5 uncontrolled", r_vec, 10'h000);

        // R6: controlled x+2 on line2 by line0
        wgene(0, 0, 2, 2);
        run(10'h012, 1, 2, "R7 latency");
        check(r_vec == 10'h002, "R6 fires on control 2", r_vec, 10'h002);
        run(10'h011, 1, 0, "R7 latency");
        check(r_vec == 10'h011, "R6 no fire on control 1", r_vec, 10'h011);

        // R4: every kind on every trit value
        for (int k = 1; k <= 5; k++) begin
            wgene(0, 0, 0, k);
            for (int x = 0; x < 3; x++) begin
                int e;
                case (k)
                    1: e = (x + 1) % 3;
                    2: e = (x + 2) % 3;
                    3: e = (2 * x + 1) % 3;
                    4: e = (2 * x + 2) % 3;
                    default: e = (2 * x) % 3;
                endcase
                run(10'(x), 1, 0, "R7 latency");
                check(int'(r_vec[1:0]) == e, "R4 kind table", int'(r_vec[1:0]), e);
            end
        end

        // R11: line4 lives at bits 9:8
        wgene(0, 4, 4, 1);
        run(10'h100, 1, 0, "R7 latency");
        check(r_vec == 10'h200, "R11 line position", r_vec, 10'h200);

        // R9: illegal code on line3 sets flag and survives a gate on it
        wgene(0, 3, 3, 1);
        run(10'h0C0, 1, 0, "R7 latency");
        check(r_et == 1'b1 && r_vec == 10'h0C0, "R9 illegal trit", {r_et, r_vec}, {1'b1, 10'h0C0});

        // R10: kind 6 and out-of-range target act as identity with flag
        wgene(0, 1, 1, 6);
        run(10'h004, 1, 0, "R7 latency");
        check(r_eg == 1'b1 && r_vec == 10'h004, "R10 kind 6", {r_eg, r_vec}, {1'b1, 10'h004});
        wgene(0, 0, 5, 1);
        run(10'h002, 1, 0, "R7 latency");
        check(r_eg == 1'b1 && r_vec == 10'h002, "R10 line index", {r_eg, r_vec}, {1'b1, 10'h002});

        // R3: oversize count clamps to MAX_COLS
        wgene(0, 0, 0, 0);
        for (int c = 1; c < MC; c++) wgene(c, 0, 0, (c % 2) ? 1 : 0);
        wcnt(40);
        run(10'h000, MC, 0, "R3 clamp latency");
        check(r_vec == 10'h001, "R3 clamp result", r_vec, 10'h001);

        // R2: writes during a run are ignored
        @(negedge clk);
        in_valid = 1; in_vec = 10'h000;
        @(negedge clk);
        in_valid = 0;
        gene_we = 1; gene_addr = 5'd0; gene_ctrl = 3'd0; gene_tgt = 3'd0; gene_kind = 3'd2;
        cnt_we = 1; cnt_val = 6'd1;
        @(negedge clk);
        gene_we = 0; cnt_we = 0;
        while (!out_valid) @(negedge clk);
        out_ready = 1;
        @(negedge clk);
        out_ready = 0;
        run(10'h000, MC, 0, "R2 count unchanged");
        check(r_vec == 10'h001, "R2 genes unchanged", r_vec, 10'h001);

        // Mixed programs with varied hold times
        lfsr = 16'hACE1;
        for (int p = 0; p < 6; p++) begin
            int n;
            for (int c = 0; c < 16; c++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                wgene(c, int'(lfsr[2:0]) % 6, int'(lfsr[5:3]) % 6, int'(lfsr[8:6]));
            end
            n = 8 + p;
            wcnt(n);
            for (int q = 0; q < 4; q++) begin
                logic [VW-1:0] v;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                for (int i = 0; i < NL; i++) v[2*i +: 2] = 2'(int'(lfsr[2*i +: 2]) % 3);
                run(v, n, q, "R7 mixed latency");
            end
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule